// File: doc/BRIEF.md
# Audio Silence Detector with Hysteresis

This block watches a stream of audio sample magnitudes and decides when the input has fallen silent and when it has come back. Time is measured in windows built from a prescaled tick of the system clock. While the input is active, a window that ends with too few samples above a low amplitude threshold puts the block into the silent state. While silent, a window in which too many samples rise above a separate, higher threshold brings it straight back out. Using two thresholds and two count limits gives hysteresis, so input that hovers between the two levels cannot make the mute toggle.

In the silent state the block drives a mute output and a status flag. It can also request that the output amplifier be powered down. Threshold and count codes are 3-bit values that the block expands to powers of two. A long-window bit stretches the programmable window by a further power-of-two factor, so that with a slow tick the longest window reaches about a minute. Detection runs only while the active-low enable is held low.

Top module: `silence_detector`

## Requirements
- R1: While `detect_en_n` is 1, and during reset, `mute`, `silence_flag` and `pa_powerdown` are 0 one clock later and stay 0. Counters and timebase are cleared, so the first window after `detect_en_n` falls starts fresh.
- R2: A window lasts TICK_DIV × BASE_WIN_TICKS × 2^(`win_code` + LONG_SHIFT·`long_win`) clock cycles, measured from the release of the enable or from the previous window boundary. With the defaults this is 8 cycles for code 0, 16 for code 1 and 64 for code 0 with the long bit set.
- R3: When not silent, the block counts the valid samples of a window whose magnitude is above 2^(`lo_thr_code`+3), including the sample on the window's last cycle. If that count is below 2^`lo_cnt_code`, `mute` and `silence_flag` go to 1 on the clock edge that ends the window.
- R4: A magnitude exactly equal to a threshold does not count as above it.
- R5: When silent, the block counts the valid samples above 2^(`hi_thr_code`+3) within the current window. On the edge where the count first exceeds 2^`hi_cnt_code`, `mute` and `silence_flag` clear and a new window starts. Samples between the two thresholds never end silence.
- R6: While silent, the high count restarts at every window boundary, so loud samples spread over different windows do not add up.
- R7: `pa_powerdown` is 1 exactly when the block is silent and `auto_pd_en` is 1. It follows `auto_pd_en` without a clock delay.
- R8: A cycle with `sample_valid` at 0 is not counted, whatever its magnitude.
- R9: The sample counter saturates at 2^CNT_W−1 instead of wrapping. A long window of loud samples therefore never appears silent.
- R10: When the exit count is crossed on the last cycle of a window, the exit wins: mute clears on that edge and a full new window follows before silence can be found again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| detect_en_n | input | 1 | Active-low detection enable; 1 clears the block |
| sample_valid | input | 1 | Strobe marking a new sample magnitude |
| sample_mag | input | MAG_W | Sample magnitude |
| lo_thr_code | input | 3 | Entry threshold code |
| hi_thr_code | input | 3 | Exit threshold code |
| lo_cnt_code | input | 3 | Entry count limit code |
| hi_cnt_code | input | 3 | Exit count limit code |
| win_code | input | 3 | Window length code |
| long_win | input | 1 | Long-window extension |
| auto_pd_en | input | 1 | Allow amplifier power-down request |
| mute | output | 1 | Mute while silent |
| silence_flag | output | 1 | Status: silence detected |
| pa_powerdown | output | 1 | Amplifier power-down request |

## Verification
The window boundary and the exit-count crossing can fall in the same cycle. The bench provokes this by placing the second loud sample of a silent window on that window's final cycle. It then checks that mute clears on that very edge, not one window later. It also checks that re-entry needs a complete new quiet window counted from that edge. A second coincidence is a sample on a window's last cycle during entry evaluation. Vectors sized to the exact window length show that this sample is included in the entry decision.

// File: rtl/sd_pkg.sv
package sd_pkg;

  typedef enum logic {
    SD_ACTIVE = 1'b0,
    SD_SILENT = 1'b1
  } sd_mode_e;

  // Expand a small code to a power of two; out-of-range exponents give zero.
  function automatic logic [31:0] sd_pow2(input int unsigned e);
    if (e > 31) return 32'd0;
    return 32'd1 << e;
  endfunction

endpackage

// File: rtl/sd_timebase.sv
module sd_timebase #(
  parameter int unsigned TICK_DIV       = 4,
  parameter int unsigned BASE_WIN_TICKS = 2,
  parameter int unsigned LONG_SHIFT     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] win_code,
  input  logic       long_win,
  output logic       win_end
);

  localparam int unsigned WIN_MAX = BASE_WIN_TICKS << (7 + LONG_SHIFT);
  localparam int unsigned WCNT_W  = $clog2(WIN_MAX + 1);

  logic tick;

  generate
    if (TICK_DIV <= 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int unsigned PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_last;

      assign pre_last = (pre_q == PRE_W'(TICK_DIV - 1));

      always_comb begin
        if (clr || pre_last) pre_d = '0;
        else                 pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick = pre_last;
    end
  endgenerate

  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [31:0]       win_len;
  logic              at_last;
  logic              wcnt_en;

  assign win_len = 32'(BASE_WIN_TICKS) << (32'(win_code) + (long_win ? LONG_SHIFT : 32'd0));
  assign at_last = ((32'(wcnt_q) + 32'd1) >= win_len);
  assign win_end = tick && at_last;
  assign wcnt_en = clr || tick;

  always_comb begin
    wcnt_d = wcnt_q;
    if (clr)          wcnt_d = '0;
    else if (at_last) wcnt_d = '0;
    else              wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wcnt_q <= '0;
    else if (wcnt_en) wcnt_q <= wcnt_d;
  end

endmodule

// File: rtl/sd_level_cmp.sv
module sd_level_cmp #(
  parameter int unsigned MAG_W     = 12,
  parameter int unsigned THR_SHIFT = 3
) (
  input  logic             sample_valid,
  input  logic [MAG_W-1:0] sample_mag,
  input  logic             use_high,
  input  logic [2:0]       lo_thr_code,
  input  logic [2:0]       hi_thr_code,
  output logic             hit
);

  import sd_pkg::*;

  logic [2:0]  code_sel;
  logic [31:0] level;

  assign code_sel = use_high ? hi_thr_code : lo_thr_code;
  assign level    = sd_pow2(32'(code_sel) + THR_SHIFT);
  assign hit      = sample_valid && (32'(sample_mag) > level);

endmodule

// File: rtl/sd_sat_counter.sv
module sd_sat_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_incl
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d;

  assign cnt_incl = (inc && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_incl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/silence_detector.sv
module silence_detector #(
  parameter int unsigned MAG_W          = 12,
  parameter int unsigned CNT_W          = 8,
  parameter int unsigned THR_SHIFT      = 3,
  parameter int unsigned TICK_DIV       = 4,
  parameter int unsigned BASE_WIN_TICKS = 2,
  parameter int unsigned LONG_SHIFT     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             detect_en_n,
  input  logic             sample_valid,
  input  logic [MAG_W-1:0] sample_mag,
  input  logic [2:0]       lo_thr_code,
  input  logic [2:0]       hi_thr_code,
  input  logic [2:0]       lo_cnt_code,
  input  logic [2:0]       hi_cnt_code,
  input  logic [2:0]       win_code,
  input  logic             long_win,
  input  logic             auto_pd_en,
  output logic             mute,
  output logic             silence_flag,
  output logic             pa_powerdown
);

  import sd_pkg::*;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  sd_mode_e         mode_q, mode_d;
  logic             silent;
  logic             hit;
  logic             win_end;
  logic             tb_clr;
  logic             cnt_clr;
  logic             enter;
  logic             leave;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_incl;
  logic [31:0]      lo_lim;
  logic [31:0]      hi_lim;

  assign silent = (mode_q == SD_SILENT);

  sd_level_cmp #(.MAG_W(MAG_W), .THR_SHIFT(THR_SHIFT)) u_cmp (
    .sample_valid (sample_valid),
    .sample_mag   (sample_mag),
    .use_high     (silent),
    .lo_thr_code  (lo_thr_code),
    .hi_thr_code  (hi_thr_code),
    .hit          (hit)
  );

  sd_timebase #(
    .TICK_DIV       (TICK_DIV),
    .BASE_WIN_TICKS (BASE_WIN_TICKS),
    .LONG_SHIFT     (LONG_SHIFT)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (tb_clr),
    .win_code (win_code),
    .long_win (long_win),
    .win_end  (win_end)
  );

  sd_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (cnt_clr),
    .inc      (hit),
    .cnt_q    (cnt_q),
    .cnt_incl (cnt_incl)
  );

  assign lo_lim = sd_pow2(32'(lo_cnt_code));
  assign hi_lim = sd_pow2(32'(hi_cnt_code));

  assign enter = !detect_en_n && !silent && win_end && (32'(cnt_incl) < lo_lim);
  assign leave = !detect_en_n && silent && (32'(cnt_incl) > hi_lim);

  assign tb_clr  = detect_en_n || leave;
  assign cnt_clr = detect_en_n || leave || win_end;

  always_comb begin
    mode_d = mode_q;
    if (detect_en_n)  mode_d = SD_ACTIVE;
    else if (leave)   mode_d = SD_ACTIVE;
    else if (enter)   mode_d = SD_SILENT;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) mode_q <= SD_ACTIVE;
    else        mode_q <= mode_d;
  end

  assign mute         = silent;
  assign silence_flag = silent;
  assign pa_powerdown = silent && auto_pd_en;

endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
  parameter int unsigned MAG_W     = 12,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned THR_SHIFT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             detect_en_n,
  input logic             sample_valid,
  input logic [MAG_W-1:0] sample_mag,
  input logic [2:0]       hi_thr_code,
  input logic             auto_pd_en,
  input logic             mute,
  input logic             silence_flag,
  input logic             pa_powerdown,
  input logic             win_end,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_clr
);

  import sd_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [31:0] hi_level;
  assign hi_level = sd_pow2(32'(hi_thr_code) + THR_SHIFT);

  p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    detect_en_n |=> (!mute && !silence_flag && !pa_powerdown))
    else $error("R1 outputs not cleared while disabled");

  p_enter_on_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute) |-> $past(win_end))
    else $error("R3 silence entered off a window boundary");

  p_exit_needs_loud_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mute) && !$past(detect_en_n)) |->
      ($past(sample_valid) && (32'($past(sample_mag)) > $past(hi_level))))
    else $error("R5 silence left without a loud sample");

  p_pd_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (silence_flag && auto_pd_en) |-> pa_powerdown)
    else $error("R7 power-down request missing");

  p_pd_needs_silence_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pa_powerdown |-> (silence_flag && auto_pd_en))
    else $error("R7 power-down request without silence");

  p_idle_holds_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !cnt_clr) |=> $stable(cnt))
    else $error("R8 count moved on an invalid cycle");

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == CNT_MAX) && !cnt_clr) |=> (cnt == CNT_MAX))
    else $error("R9 count wrapped");

endmodule

bind silence_detector sd_checker #(
  .MAG_W     (MAG_W),
  .CNT_W     (CNT_W),
  .THR_SHIFT (THR_SHIFT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .detect_en_n  (detect_en_n),
  .sample_valid (sample_valid),
  .sample_mag   (sample_mag),
  .hi_thr_code  (hi_thr_code),
  .auto_pd_en   (auto_pd_en),
  .mute         (mute),
  .silence_flag (silence_flag),
  .pa_powerdown (pa_powerdown),
  .win_end      (win_end),
  .cnt          (cnt_q),
  .cnt_clr      (cnt_clr)
);

// File: tb/silence_detector_test.sv
module silence_detector_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAG_W      = 12;

  logic             clk;
  logic             rst_n;
  logic             detect_en_n;
  logic             sample_valid;
  logic [MAG_W-1:0] sample_mag;
  logic [2:0]       lo_thr_code, hi_thr_code, lo_cnt_code, hi_cnt_code, win_code;
  logic             long_win, auto_pd_en;
  logic             mute, silence_flag, pa_powerdown;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  silence_detector uut (
    .clk(clk), .rst_n(rst_n), .detect_en_n(detect_en_n),
    .sample_valid(sample_valid), .sample_mag(sample_mag),
    .lo_thr_code(lo_thr_code), .hi_thr_code(hi_thr_code),
    .lo_cnt_code(lo_cnt_code), .hi_cnt_code(hi_cnt_code),
    .win_code(win_code), .long_win(long_win), .auto_pd_en(auto_pd_en),
    .mute(mute), .silence_flag(silence_flag), .pa_powerdown(pa_powerdown)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]  lo;
    logic [2:0]  hi;
    logic [2:0]  lc;
    logic [2:0]  hc;
    logic [2:0]  win;
    logic        lng;
    logic        apd;
    logic        vld;
    logic [11:0] mag;
    logic [15:0] cyc;
    logic        em;
    logic        ep;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  // Default timing: 4-cycle tick, 2 ticks base, so code 0 = 8 cycles.
  localparam vec_t VECS [NV] = '{
    '{3'd0,3'd1,3'd0,3'd0,3'd0,1'b0,1'b1,1'b1,12'd0,  16'd8,  1'b1,1'b1,8'd3}, // R3 quiet window
    '{3'd0,3'd1,3'd0,3'd0,3'd0,1'b0,1'b1,1'b1,12'd0,  16'd7,  1'b0,1'b0,8'd2}, // R2 one short
    '{3'd0,3'd1,3'd0,3'd0,3'd0,1'b0,1'b1,1'b1,12'd8,  16'd8,  1'b1,1'b1,8'd4}, // R4 equal level
    '{3'd0,3'd1,3'd0,3'd0,3'd0,1'b0,1'b1,1'b1,12'd9,  16'd8,  1'b0,1'b0,8'd3}, // R3 loud window
    '{3'd0,3'd1,3'd0,3'd0,3'd0,1'b0,1'b1,1'b0,12'd100,16'd8,  1'b1,1'b1,8'd8}, // R8 invalid loud
    '{3'd0,3'd1,3'd0,3'd0,3'd0,1'b0,1'b0,1'b1,12'd0,  16'd8,  1'b1,1'b0,8'd7}, // R7 no pd
    '{3'd0,3'd1,3'd0,3'd0,3'd1,1'b0,1'b1,1'b1,12'd0,  16'd15, 1'b0,1'b0,8'd2}, // R2 code 1 short
    '{3'd0,3'd1,3'd0,3'd0,3'd1,1'b0,1'b1,1'b1,12'd0,  16'd16, 1'b1,1'b1,8'd2}, // R2 code 1
    '{3'd0,3'd1,3'd0,3'd0,3'd0,1'b1,1'b1,1'b1,12'd0,  16'd63, 1'b0,1'b0,8'd2}, // R2 long short
    '{3'd0,3'd1,3'd0,3'd0,3'd0,1'b1,1'b1,1'b1,12'd0,  16'd64, 1'b1,1'b1,8'd2}, // R2 long
    '{3'd0,3'd1,3'd3,3'd0,3'd0,1'b0,1'b1,1'b1,12'd9,  16'd8,  1'b0,1'b0,8'd3}, // R3 8 not below 8
    '{3'd0,3'd1,3'd4,3'd0,3'd0,1'b0,1'b1,1'b1,12'd9,  16'd8,  1'b1,1'b1,8'd3}, // R3 8 below 16
    '{3'd0,3'd1,3'd7,3'd0,3'd6,1'b0,1'b1,1'b1,12'd9,  16'd512,1'b0,1'b0,8'd9}, // R9 512 loud
    '{3'd2,3'd3,3'd0,3'd0,3'd0,1'b0,1'b1,1'b1,12'd20, 16'd8,  1'b1,1'b1,8'd3}  // R3 level 32
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk3(input logic em, input logic ep, input string tag);
    chk(mute,         em, {tag, " mute"});
    chk(silence_flag, em, {tag, " flag"});
    chk(pa_powerdown, ep, {tag, " pd"});
  endtask

  // Starts and ends at a falling edge.
  task automatic run(input int n, input logic v, input logic [MAG_W-1:0] m);
    for (int k = 0; k < n; k++) begin
      sample_valid = v;
      sample_mag   = m;
      @(negedge clk);
    end
  endtask

  task automatic restart_en();
    detect_en_n = 1'b1;
    run(2, 1'b0, '0);
    detect_en_n = 1'b0;
  endtask

  // Default config, then one quiet window: silent after edge 8.
  task automatic enter_silence();
    lo_thr_code = 3'd0; hi_thr_code = 3'd1; lo_cnt_code = 3'd0; hi_cnt_code = 3'd0;
    win_code = 3'd0; long_win = 1'b0; auto_pd_en = 1'b1;
    restart_en();
    run(8, 1'b1, '0);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0; detect_en_n = 1'b1; sample_valid = 1'b0; sample_mag = '0;
    lo_thr_code = '0; hi_thr_code = '0; lo_cnt_code = '0; hi_cnt_code = '0;
    win_code = '0; long_win = 1'b0; auto_pd_en = 1'b1;
    repeat (3) @(negedge clk);
    chk3(1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      lo_thr_code = VECS[i].lo;  hi_thr_code = VECS[i].hi;
      lo_cnt_code = VECS[i].lc;  hi_cnt_code = VECS[i].hc;
      win_code    = VECS[i].win; long_win    = VECS[i].lng;
      auto_pd_en  = VECS[i].apd;
      restart_en();
      run(int'(VECS[i].cyc), VECS[i].vld, VECS[i].mag);
      chk3(VECS[i].em, VECS[i].ep, $sformatf("R%0d vec %0d", VECS[i].req, i));
    end

    // R5 exit after count passes limit, then fresh window
    enter_silence();
    chk3(1'b1, 1'b1, "R5 entered");
    run(1, 1'b1, 12'd17);
    chk3(1'b1, 1'b1, "R5 one loud");
    run(1, 1'b1, 12'd17);
    chk3(1'b0, 1'b0, "R5 two loud exit");
    run(7, 1'b1, '0);
    chk3(1'b0, 1'b0, "R5 restart short");
    run(1, 1'b1, '0);
    chk3(1'b1, 1'b1, "R5 restart full");

    // R5 hysteresis band
    enter_silence();
    run(20, 1'b1, 12'd12);
    chk3(1'b1, 1'b1, "R5 mid band");

    // R4 equal to high level
    enter_silence();
    run(4, 1'b1, 12'd16);
    chk3(1'b1, 1'b1, "R4 equal high");

    // R6 loud samples in separate windows
    enter_silence();
    run(3, 1'b1, '0);
    run(1, 1'b1, 12'd17);
    run(7, 1'b1, '0);
    run(1, 1'b1, 12'd17);
    run(4, 1'b1, '0);
    chk3(1'b1, 1'b1, "R6 split windows");

    // R10 exit crossing on window end cycle
    enter_silence();
    run(6, 1'b1, '0);
    run(1, 1'b1, 12'd17);
    chk3(1'b1, 1'b1, "R10 before end");
    run(1, 1'b1, 12'd17);
    chk3(1'b0, 1'b0, "R10 exit at end");
    run(7, 1'b1, '0);
    chk3(1'b0, 1'b0, "R10 new window short");
    run(1, 1'b1, '0);
    chk3(1'b1, 1'b1, "R10 new window full");

    // R7 power-down follows its enable at once
    auto_pd_en = 1'b0;
    #1;
    chk3(1'b1, 1'b0, "R7 pd off");
    auto_pd_en = 1'b1;
    #1;
    chk3(1'b1, 1'b1, "R7 pd on");
    @(negedge clk);

    // R1 disable clears and restarts
    detect_en_n = 1'b1;
    run(1, 1'b1, '0);
    chk3(1'b0, 1'b0, "R1 disable");
    run(20, 1'b1, '0);
    chk3(1'b0, 1'b0, "R1 held");
    detect_en_n = 1'b0;
    run(7, 1'b1, '0);
    chk3(1'b0, 1'b0, "R1 fresh short");
    run(1, 1'b1, '0);
    chk3(1'b1, 1'b1, "R1 fresh full");

    done = 1;
    finish_up();
  end

endmodule